// File: doc/BRIEF.md
# Maskable Three-Source Interrupt Controller

This block gathers three timekeeper interrupt causes (alarm match, periodic rate tick and end of update) into a single active-low, open-drain request line. Each cause has a sticky pending flag and a software enable bit. A flag is set by a one-cycle event pulse whether or not its enable is set. The request line is pulled low while at least one pending flag has its enable set. A summary bit in the status byte reports that same condition.

Software clears pending causes by reading the status byte. The read returns the values held at that moment, and all flags are cleared on the clock edge that ends the read. A control byte holds the three enables, a square-wave output enable and four general mode bits. The block's reset input clears the enables, the square-wave enable and the flags. It leaves the mode bits alone. While that reset is low, the block ignores every access and every event. The event sources and the address decoding sit outside this block.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: An event pulse (`evt_update`, `evt_alarm`, `evt_periodic`) sets its flag on the next clock edge, whatever the state of its enable. In the status byte the flags sit at bit 4 (update), bit 5 (alarm) and bit 6 (periodic).
- R2: Status bit 7 is the summary flag. It is 1 exactly when some flag is set together with its enable. Status bits 3..0 always read 0.
- R3: `irq_drive_low` is 1 while any enabled flag is pending and stays 1 until that condition ends. It is 0 otherwise, so the line floats to the external pull-up.
- R4: While `stat_rd` is high, `stat_data` shows the current flags. All flags are 0 after the clock edge that ends the read.
- R5: If a flag's event arrives in the same cycle as a clearing read, that flag remains set after the read. The other flags are cleared.
- R6: A write with `wr_sel`=0 loads `wr_data` into the control byte on the next edge. The enables sit at the same bit positions as their flags: update bit 4, alarm bit 5, periodic bit 6. The square-wave enable is bit 3. `ctrl_data` and `sqw_en` show the stored values.
- R7: A write with `wr_sel`=1 addresses the status byte and changes neither the control byte nor any flag.
- R8: While `rst_n` is low, control bits 6..3 and all flags are cleared. Control bits 7 and 2..0 keep their values.
- R9: While `rst_n` is low, writes, status reads and events have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset input; performs the partial clear |
| evt_alarm | input | 1 | Alarm-match event pulse |
| evt_periodic | input | 1 | Periodic-rate event pulse |
| evt_update | input | 1 | End-of-update event pulse |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 control byte, 1 status byte (ignored) |
| wr_data | input | 8 | Write data |
| stat_rd | input | 1 | Status read strobe; clears flags at the end of the read |
| stat_data | output | 8 | Status byte: summary, periodic, alarm, update flags |
| ctrl_data | output | 8 | Control byte readback |
| sqw_en | output | 1 | Square-wave output enable |
| irq_drive_low | output | 1 | Pull-down enable for the open-drain request line |

## Verification
A clearing status read and a new event pulse can land in the same cycle. The bench holds `stat_rd` high and pulses an event during that one clock. It uses an event for a flag that is already set and an event for one that is clear. After that edge it compares the status byte against the expected result: the colliding flag survives and the others are gone. The same collision is checked against the request line. A surviving flag that is not enabled must not hold the line low. A surviving flag that is enabled must keep it asserted.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    localparam int NSRC     = 3;
    localparam int RW       = 8;
    localparam int FLAG_LSB = 4;
    localparam int SUM_BIT  = 7;
    localparam int SQW_BIT  = 3;

    typedef enum logic [1:0] {
        SRC_UPD = 2'd0,
        SRC_ALM = 2'd1,
        SRC_PER = 2'd2
    } src_e;

    typedef logic [NSRC-1:0] srcvec_t;

    typedef struct packed {
        srcvec_t flags;
    } flag_st_t;

    typedef struct packed {
        logic [RW-1:0] ctrl;
    } ctrl_st_t;

endpackage

// File: rtl/rtc_irq_flag_bank.sv
module rtc_irq_flag_bank
    import rtc_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  srcvec_t evt,
    input  logic    clr_rd,
    output srcvec_t flags
);

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.flags = '0;
        end else begin
            for (int i = 0; i < NSRC; i++) begin
                if (evt[i]) begin
                    st_d.flags[i] = 1'b1;
                end else if (clr_rd) begin
                    st_d.flags[i] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign flags = st_q.flags;

    for (genvar g = 0; g < NSRC; g++) begin : g_chk
        AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            evt[g] |=> flags[g]);                                   // R1
        AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_rd && !evt[g]) |=> !flags[g]);                     // R4
        AST_COLLIDE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_rd && evt[g]) |=> flags[g]);                       // R5
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[g] && !clr_rd) |=> flags[g]);                    // R1
    end

endmodule

// File: rtl/rtc_irq_ctrl_reg.sv
module rtc_irq_ctrl_reg
    import rtc_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [RW-1:0] wr_data,
    output logic [RW-1:0] ctrl
);

    localparam logic [RW-1:0] ENA_MASK = RW'(((1 << NSRC) - 1) << FLAG_LSB);
    localparam logic [RW-1:0] CLR_MASK = ENA_MASK | RW'(1 << SQW_BIT);

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.ctrl = st_q.ctrl & ~CLR_MASK;
        end else if (wr_en && !wr_sel) begin
            st_d.ctrl = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ctrl = st_q.ctrl;

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> (ctrl == $past(wr_data)));           // R6
    AST_STAT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> $stable(ctrl));                       // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl));                                  // R6

endmodule

// File: rtl/rtc_irq_summary.sv
module rtc_irq_summary
    import rtc_irq_pkg::*;
(
    input  srcvec_t       flags,
    input  srcvec_t       enables,
    output logic [RW-1:0] stat_byte,
    output logic          req
);

    srcvec_t pend;

    always_comb begin
        pend      = flags & enables;
        req       = |pend;
        stat_byte = '0;
        stat_byte[SUM_BIT]              = req;
        stat_byte[FLAG_LSB +: NSRC]     = flags;
    end

    always_comb begin
        assert (stat_byte[FLAG_LSB-1:0] == '0);                     // R2
    end

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_alarm,
    input  logic       evt_periodic,
    input  logic       evt_update,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       stat_rd,
    output logic [7:0] stat_data,
    output logic [7:0] ctrl_data,
    output logic       sqw_en,
    output logic       irq_drive_low
);

    srcvec_t       evt_vec;
    srcvec_t       flags;
    srcvec_t       enables;
    logic [RW-1:0] ctrl;
    logic [RW-1:0] stat_byte;
    logic          req;

    always_comb begin
        evt_vec          = '0;
        evt_vec[SRC_UPD] = evt_update;
        evt_vec[SRC_ALM] = evt_alarm;
        evt_vec[SRC_PER] = evt_periodic;
    end

    rtc_irq_flag_bank u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt_vec),
        .clr_rd (stat_rd),
        .flags  (flags)
    );

    rtc_irq_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ctrl    (ctrl)
    );

    assign enables = ctrl[FLAG_LSB +: NSRC];

    rtc_irq_summary u_sum (
        .flags     (flags),
        .enables   (enables),
        .stat_byte (stat_byte),
        .req       (req)
    );

    assign stat_data     = stat_byte;
    assign ctrl_data     = ctrl;
    assign sqw_en        = ctrl[SQW_BIT];
    assign irq_drive_low = req;

    AST_REQ_DROPS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !evt_alarm && !evt_periodic && !evt_update) |=> !irq_drive_low); // R3
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_drive_low && !stat_rd && !wr_en) |=> irq_drive_low);   // R3
    AST_EVT_IN_RESET_IGNORED: assert property (@(posedge clk)
        !rst_n |=> (stat_data == 8'h00));                           // R8

endmodule

// File: tb/rtc_irq_ctrl_tb.sv
module rtc_irq_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       evt_alarm, evt_periodic, evt_update;
    logic       wr_en, wr_sel;
    logic [7:0] wr_data;
    logic       stat_rd;
    logic [7:0] stat_data, ctrl_data;
    logic       sqw_en, irq_drive_low;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rtc_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .evt_alarm(evt_alarm), .evt_periodic(evt_periodic), .evt_update(evt_update),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .stat_rd(stat_rd),
        .stat_data(stat_data), .ctrl_data(ctrl_data), .sqw_en(sqw_en),
        .irq_drive_low(irq_drive_low)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_ctrl(input logic [7:0] d);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic a, input logic p, input logic u);
        evt_alarm = a; evt_periodic = p; evt_update = u;
        step();
        evt_alarm = 1'b0; evt_periodic = 1'b0; evt_update = 1'b0;
    endtask

    task automatic rd_status(input logic [7:0] exp_during, input string req);
        stat_rd = 1'b1;
        #2;
        chk(req, stat_data, exp_during);
        step();
        stat_rd = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        chk("R8 flags after reset", stat_data, 8'h00);
        chk("R8 enables after reset", ctrl_data & 8'h78, 8'h00);
        chk("R8 sqw after reset", {7'd0, sqw_en}, 8'h00);
        chk("R3 idle request", {7'd0, irq_drive_low}, 8'h00);
    endtask

    task automatic t_flag_no_enable();
        wr_ctrl(8'h00);
        pulse(1'b1, 1'b0, 1'b0);
        chk("R1 alarm flag without enable", stat_data, 8'h20);
        chk("R3 no request when disabled", {7'd0, irq_drive_low}, 8'h00);
        rd_status(8'h20, "R4 read returns current");
        chk("R4 cleared after read", stat_data, 8'h00);
    endtask

    task automatic t_enabled();
        wr_ctrl(8'h40);
        pulse(1'b0, 1'b1, 1'b0);
        chk("R2 periodic enabled summary", stat_data, 8'hC0);
        chk("R3 request asserted", {7'd0, irq_drive_low}, 8'h01);
        step(); step();
        chk("R3 request held", {7'd0, irq_drive_low}, 8'h01);
        pulse(1'b0, 1'b0, 1'b1);
        chk("R1 update flag added", stat_data, 8'hD0);
        rd_status(8'hD0, "R4 read shows both");
        chk("R4 all cleared", stat_data, 8'h00);
        chk("R3 request released", {7'd0, irq_drive_low}, 8'h00);
    endtask

    task automatic t_late_enable();
        wr_ctrl(8'h00);
        pulse(1'b0, 1'b0, 1'b1);
        chk("R1 update flag no enable", stat_data, 8'h10);
        chk("R3 no request yet", {7'd0, irq_drive_low}, 8'h00);
        wr_ctrl(8'h10);
        chk("R2 summary after late enable", stat_data, 8'h90);
        chk("R3 request after late enable", {7'd0, irq_drive_low}, 8'h01);
        rd_status(8'h90, "R4 read late");
    endtask

    task automatic t_collide();
        wr_ctrl(8'h20);
        pulse(1'b1, 1'b0, 1'b1);
        chk("R2 alarm enabled summary", stat_data, 8'hB0);
        stat_rd = 1'b1; evt_periodic = 1'b1;
        step();
        stat_rd = 1'b0; evt_periodic = 1'b0;
        chk("R5 new event survives read", stat_data, 8'h40);
        chk("R5 request off for disabled survivor", {7'd0, irq_drive_low}, 8'h00);
        pulse(1'b1, 1'b0, 1'b0);
        stat_rd = 1'b1; evt_alarm = 1'b1;
        step();
        stat_rd = 1'b0; evt_alarm = 1'b0;
        chk("R5 set flag kept on collision", stat_data, 8'hA0);
        chk("R5 request kept for enabled survivor", {7'd0, irq_drive_low}, 8'h01);
        rd_status(8'hA0, "R4 final read");
    endtask

    task automatic t_writes();
        wr_ctrl(8'h7B);
        chk("R6 control readback", ctrl_data, 8'h7B);
        chk("R6 sqw enable", {7'd0, sqw_en}, 8'h01);
        wr_ctrl(8'h87);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'hFF;
        step();
        wr_en = 1'b0; wr_sel = 1'b0;
        chk("R7 status write leaves control", ctrl_data, 8'h87);
        chk("R7 status write leaves flags", stat_data, 8'h00);
    endtask

    task automatic t_partial_reset();
        wr_ctrl(8'hFF);
        pulse(1'b1, 1'b1, 1'b1);
        chk("R2 all pending", stat_data, 8'hF0);
        rst_n = 1'b0;
        step();
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h00;
        evt_alarm = 1'b1; evt_periodic = 1'b1; evt_update = 1'b1; stat_rd = 1'b1;
        step();
        wr_en = 1'b0; evt_alarm = 1'b0; evt_periodic = 1'b0; evt_update = 1'b0; stat_rd = 1'b0;
        rst_n = 1'b1;
        chk("R8 R9 mode bits kept, enables cleared", ctrl_data, 8'h87);
        chk("R9 events in reset ignored", stat_data, 8'h00);
        chk("R8 sqw cleared", {7'd0, sqw_en}, 8'h00);
        chk("R8 request released", {7'd0, irq_drive_low}, 8'h00);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; evt_alarm = 1'b0; evt_periodic = 1'b0; evt_update = 1'b0;
        wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00; stat_rd = 1'b0;
        #3;
        t_reset();
        t_flag_no_enable();
        t_enabled();
        t_late_enable();
        t_collide();
        t_writes();
        t_partial_reset();
        step();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule